// File: doc/BRIEF.md
# Temperature Sensor Command Sequencer

This block drives the user side of a byte-level two-wire bus controller so that a digital temperature sensor is first set to its finest resolution and then read. It issues three bus transactions in a fixed order. The first writes the configuration register. The second points the sensor at its temperature register. The third reads two bytes back. The block then presents a 12-bit temperature word with a one-cycle valid strobe.

The controller takes a command while it is idle, and again each time its busy line drops at the end of a byte. The sequencer therefore moves one step forward on every falling edge of busy. It holds the enable high while more bytes of the same transaction are due. It drops the enable once the last byte has been accepted, which makes the controller close the transaction with a STOP. The controller's busy line then drops a final time when the bus returns to idle, and only then does the next transaction begin.

A `start` pulse runs the whole sequence. Once the pointer has been left on the temperature register, a `reread` pulse repeats only the read transaction. A missing acknowledge ends the sequence and raises a sticky error flag.

Top module: `tsens_i2c_seq`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `ctl_ena`, `err` and `temp_valid` are 0 and `temp` is 0.
- R2: A `start` pulse while idle raises `ctl_ena` on the next edge, with `ctl_addr` = 7'b1001000, `ctl_rnw` = 0 (0 means write) and `ctl_wr_data` = 0x01. The low two bits of a pointer byte select the register: 01 selects configuration and 00 selects temperature.
- R3: On the first falling edge of `ctl_busy` in the configuration write, `ctl_wr_data` becomes 0x60 (12-bit resolution) and `ctl_ena` stays high.
- R4: On the next falling edge of `ctl_busy`, `ctl_ena` drops to request STOP.
- R5: On the falling edge of `ctl_busy` that marks the return to bus idle, the pointer write begins with `ctl_ena` = 1, `ctl_rnw` = 0 and `ctl_wr_data` = 0x00. `ctl_ena` drops on that transaction's next falling edge of `ctl_busy`.
- R6: After the pointer write's STOP, the read begins with `ctl_rnw` = 1. `ctl_ena` stays high across the first byte, which is acknowledged, and drops after the second byte, so that the controller answers it with a NACK and then STOP.
- R7: On the falling edge of `ctl_busy` that completes the second read byte, `temp` takes the value {first byte, second byte[7:4]} and `temp_valid` is high for exactly one cycle.
- R8: If `ctl_ack_err` is high while a transaction is in progress, `err` is set, `ctl_ena` drops, and the block returns to idle. `err` stays set until the next `start`.
- R9: At the start of each transaction, `ctl_ack_err` is ignored until `ctl_busy` has been seen high, so a stale flag left over from the controller's last run causes no error.
- R10: A `reread` pulse while idle, after a complete sequence, starts the read transaction directly (`ctl_ena` = 1, `ctl_rnw` = 1).
- R11: A `reread` pulse before the pointer has been set, or after an error, is ignored and `ctl_ena` stays low.
- R12: `start` and `reread` pulses while a sequence is running have no effect on the bus command.
- R13: The low nibble of the second read byte has no effect on `temp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Run configure, point and read |
| reread | input | 1 | Repeat the read transaction only |
| ctl_busy | input | 1 | Busy line from the bus controller |
| ctl_ack_err | input | 1 | Missing-acknowledge flag from the controller |
| ctl_rd_data | input | 8 | Byte read by the controller |
| ctl_ena | output | 1 | Command enable to the controller |
| ctl_addr | output | 7 | Slave address to the controller |
| ctl_rnw | output | 1 | Direction, 1 = read |
| ctl_wr_data | output | 8 | Byte to write |
| temp | output | 12 | Assembled temperature result |
| temp_valid | output | 1 | One-cycle strobe for a new `temp` |
| err | output | 1 | Sticky acknowledge error |

## Verification
The bench models the controller's busy line byte by byte and goes after the hand-off points between transactions. A design that counted the STOP-to-idle fall as a byte would skip the pointer write. A design that swapped the byte order or took the low nibble would give a wrong `temp` for patterns such as 0xA5/0x5A and 0x00/0x0F. A stale acknowledge error is held high across a new `start` to catch a sequencer that aborts on the controller's previous state. The bench also checks that a `reread` issued before configuration is refused, and that `start` or `reread` arriving in mid-sequence leaves the command unchanged.

// File: rtl/tsens_seq_pkg.sv
// Shared types for the temperature sensor command sequencer.
// Assumes one sequence step per falling edge of the controller busy line.
package tsens_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_CFG_PTR  = 4'd1,
        ST_CFG_VAL  = 4'd2,
        ST_CFG_END  = 4'd3,
        ST_TPTR     = 4'd4,
        ST_TPTR_END = 4'd5,
        ST_RD_HI    = 4'd6,
        ST_RD_LO    = 4'd7,
        ST_RD_END   = 4'd8
    } seq_state_e;

endpackage

// File: rtl/tsens_fall_det.sv
// Falling-edge detector for the controller busy line.
// Assumes busy is already synchronous to clk.
module tsens_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic fall
);

    logic level_q;

    // Remember the previous level of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    // A fall is a high-to-low change seen at this edge.
    always_comb fall = level_q & ~level;

endmodule

// File: rtl/tsens_step_dec.sv
// Decodes the sequencer state into the controller command and the next step.
// Purely combinational; assumes the pointer selector fits in the low bits of a byte.
module tsens_step_dec
    import tsens_seq_pkg::*;
#(
    parameter int          DATA_W       = 8,
    parameter int          SEL_W        = 2,
    parameter logic [SEL_W-1:0] CFG_SEL  = 2'd1,
    parameter logic [SEL_W-1:0] TEMP_SEL = 2'd0,
    parameter logic [DATA_W-1:0] CFG_VALUE = 8'h60
) (
    input  seq_state_e        state,
    output logic              ena,
    output logic              rnw,
    output logic [DATA_W-1:0] wr_data,
    output seq_state_e        nxt,
    output logic              nxt_opens,
    output logic              is_hi,
    output logic              is_lo,
    output logic              is_ptr_end
);

    localparam int PAD_W = DATA_W - SEL_W;
    localparam logic [DATA_W-1:0] PTR_CFG  = {{PAD_W{1'b0}}, CFG_SEL};
    localparam logic [DATA_W-1:0] PTR_TEMP = {{PAD_W{1'b0}}, TEMP_SEL};

    // Command presented to the controller for each step.
    always_comb begin
        ena     = 1'b0;
        rnw     = 1'b0;
        wr_data = '0;
        unique case (state)
            ST_CFG_PTR: begin ena = 1'b1; wr_data = PTR_CFG;   end
            ST_CFG_VAL: begin ena = 1'b1; wr_data = CFG_VALUE; end
            ST_TPTR:    begin ena = 1'b1; wr_data = PTR_TEMP;  end
            ST_RD_HI:   begin ena = 1'b1; rnw = 1'b1;          end
            ST_RD_LO:   begin ena = 1'b1; rnw = 1'b1;          end
            ST_RD_END:  rnw = 1'b1;
            default:    ;
        endcase
    end

    // Step taken on the next falling edge of busy.
    always_comb begin
        unique case (state)
            ST_CFG_PTR:  nxt = ST_CFG_VAL;
            ST_CFG_VAL:  nxt = ST_CFG_END;
            ST_CFG_END:  nxt = ST_TPTR;
            ST_TPTR:     nxt = ST_TPTR_END;
            ST_TPTR_END: nxt = ST_RD_HI;
            ST_RD_HI:    nxt = ST_RD_LO;
            ST_RD_LO:    nxt = ST_RD_END;
            default:     nxt = ST_IDLE;
        endcase
    end

    // Flags for the top-level control.
    always_comb begin
        nxt_opens  = (nxt == ST_TPTR) || (nxt == ST_RD_HI);
        is_hi      = (state == ST_RD_HI);
        is_lo      = (state == ST_RD_LO);
        is_ptr_end = (state == ST_TPTR_END);
    end

endmodule

// File: rtl/tsens_result.sv
// Assembles the left-justified temperature word from two read bytes.
// Assumes the high byte arrives before the low byte.
module tsens_result #(
    parameter int DATA_W = 8,
    parameter int TEMP_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_hi,
    input  logic              cap_lo,
    input  logic [DATA_W-1:0] rd_data,
    output logic [TEMP_W-1:0] temp,
    output logic              temp_valid
);

    localparam int LOW_W = TEMP_W - DATA_W;

    logic [DATA_W-1:0] hi_q;

    // Hold the first read byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_q <= '0;
        else if (cap_hi) hi_q <= rd_data;
    end

    // Build the result and strobe it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp       <= '0;
            temp_valid <= 1'b0;
        end else begin
            temp_valid <= cap_lo;
            if (cap_lo) temp <= {hi_q, rd_data[DATA_W-1 -: LOW_W]};
        end
    end

endmodule

// File: rtl/tsens_i2c_seq.sv
// Temperature sensor command sequencer: configure, point, then read.
// Assumes a byte controller that latches a command while idle or at each
// busy fall, and that closes with STOP when the enable is low.
module tsens_i2c_seq
    import tsens_seq_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int TEMP_W = 12,
    parameter int SEL_W  = 2,
    parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'b1001000,
    parameter logic [SEL_W-1:0]  CFG_SEL    = 2'd1,
    parameter logic [SEL_W-1:0]  TEMP_SEL   = 2'd0,
    parameter logic [DATA_W-1:0] CFG_VALUE  = 8'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              reread,
    input  logic              ctl_busy,
    input  logic              ctl_ack_err,
    input  logic [DATA_W-1:0] ctl_rd_data,
    output logic              ctl_ena,
    output logic [ADDR_W-1:0] ctl_addr,
    output logic              ctl_rnw,
    output logic [DATA_W-1:0] ctl_wr_data,
    output logic [TEMP_W-1:0] temp,
    output logic              temp_valid,
    output logic              err
);

    seq_state_e state;
    seq_state_e nxt;
    logic       busy_fall;
    logic       armed;
    logic       cfg_done;
    logic       abort;
    logic       nxt_opens, is_hi, is_lo, is_ptr_end;

    tsens_fall_det u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .level (ctl_busy),
        .fall  (busy_fall)
    );

    tsens_step_dec #(
        .DATA_W    (DATA_W),
        .SEL_W     (SEL_W),
        .CFG_SEL   (CFG_SEL),
        .TEMP_SEL  (TEMP_SEL),
        .CFG_VALUE (CFG_VALUE)
    ) u_dec (
        .state      (state),
        .ena        (ctl_ena),
        .rnw        (ctl_rnw),
        .wr_data    (ctl_wr_data),
        .nxt        (nxt),
        .nxt_opens  (nxt_opens),
        .is_hi      (is_hi),
        .is_lo      (is_lo),
        .is_ptr_end (is_ptr_end)
    );

    tsens_result #(
        .DATA_W (DATA_W),
        .TEMP_W (TEMP_W)
    ) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_hi     (busy_fall & is_hi & ~abort),
        .cap_lo     (busy_fall & is_lo & ~abort),
        .rd_data    (ctl_rd_data),
        .temp       (temp),
        .temp_valid (temp_valid)
    );

    // Address is fixed to the one sensor.
    always_comb ctl_addr = SLAVE_ADDR;

    // An acknowledge error counts only once this transaction has seen busy.
    always_comb abort = armed & ctl_ack_err & (state != ST_IDLE);

    // Main sequencing: start, step on busy falls, abort on error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            armed    <= 1'b0;
            cfg_done <= 1'b0;
            err      <= 1'b0;
        end else if (abort) begin
            state    <= ST_IDLE;
            armed    <= 1'b0;
            cfg_done <= 1'b0;
            err      <= 1'b1;
        end else if (state == ST_IDLE) begin
            if (start) begin
                state    <= ST_CFG_PTR;
                armed    <= 1'b0;
                cfg_done <= 1'b0;
                err      <= 1'b0;
            end else if (reread && cfg_done) begin
                state <= ST_RD_HI;
                armed <= 1'b0;
            end
        end else begin
            if (ctl_busy) armed <= 1'b1;
            if (busy_fall) begin
                state <= nxt;
                if (nxt_opens)  armed    <= 1'b0;
                if (is_ptr_end) cfg_done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tsens_seq_chk.sv
// Port-level checker for the temperature sensor command sequencer.
// Assumes the controller raises busy no earlier than the cycle after enable.
module tsens_seq_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              ctl_busy,
    input logic              ctl_ack_err,
    input logic              ctl_ena,
    input logic              ctl_rnw,
    input logic [DATA_W-1:0] ctl_wr_data,
    input logic              temp_valid,
    input logic              err
);

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        temp_valid |=> !temp_valid);

    assert_valid_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        temp_valid |-> (!$past(ctl_busy) && $past(ctl_rnw)));

    assert_err_drops_ena_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !ctl_ena);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err);

    assert_rnw_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_ena && !ctl_ack_err) |=> $stable(ctl_rnw));

    assert_data_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_busy) && !$past(ctl_ack_err)) |-> $stable(ctl_wr_data));

    assert_ena_rise_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_ena) |-> !$past(ctl_busy));

endmodule

bind tsens_i2c_seq tsens_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .ctl_busy    (ctl_busy),
    .ctl_ack_err (ctl_ack_err),
    .ctl_ena     (ctl_ena),
    .ctl_rnw     (ctl_rnw),
    .ctl_wr_data (ctl_wr_data),
    .temp_valid  (temp_valid),
    .err         (err)
);

// File: tb/tsens_i2c_seq_test.sv
// Bench for the temperature sensor command sequencer; models controller busy.
module tsens_i2c_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        reread = 1'b0;
    logic        ctl_busy = 1'b0;
    logic        ctl_ack_err = 1'b0;
    logic [7:0]  ctl_rd_data = 8'h00;
    logic        ctl_ena;
    logic [6:0]  ctl_addr;
    logic        ctl_rnw;
    logic [7:0]  ctl_wr_data;
    logic [11:0] temp;
    logic        temp_valid;
    logic        err;

    int checks = 0;
    int fails  = 0;

    // Each entry: {first byte, second byte, expected temp}.
    localparam int NV = 5;
    localparam logic [27:0] VEC [NV] = '{
        {8'h19, 8'h00, 12'h190},
        {8'hFF, 8'hF0, 12'hFFF},
        {8'h00, 8'h0F, 12'h000},
        {8'hA5, 8'h5A, 12'hA55},
        {8'h80, 8'h1F, 12'h801}
    };

    tsens_i2c_seq uut (
        .clk (clk), .rst_n (rst_n), .start (start), .reread (reread),
        .ctl_busy (ctl_busy), .ctl_ack_err (ctl_ack_err), .ctl_rd_data (ctl_rd_data),
        .ctl_ena (ctl_ena), .ctl_addr (ctl_addr), .ctl_rnw (ctl_rnw),
        .ctl_wr_data (ctl_wr_data), .temp (temp), .temp_valid (temp_valid), .err (err)
    );

    always #4 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        start = 1'b1; tick(1); start = 1'b0;
    endtask

    task automatic pulse_reread();
        reread = 1'b1; tick(1); reread = 1'b0;
    endtask

    // One byte handled by the modelled controller, ending in a busy fall.
    task automatic ctl_byte(input logic [7:0] rd);
        ctl_busy = 1'b1; tick(3);
        ctl_rd_data = rd; ctl_busy = 1'b0; tick(1);
    endtask

    // STOP then return to idle: busy high, then low.
    task automatic ctl_stop();
        ctl_busy = 1'b1; tick(3);
        ctl_busy = 1'b0; tick(1);
    endtask

    task automatic read_txn(input logic [7:0] hi, input logic [7:0] lo, input logic [11:0] exp);
        chk("R6 read ena", ctl_ena, 1);
        chk("R6 read rnw", ctl_rnw, 1);
        ctl_byte(hi);
        chk("R6 ena kept after first byte", ctl_ena, 1);
        ctl_byte(lo);
        chk("R6 ena dropped after second byte", ctl_ena, 0);
        chk("R7 valid", temp_valid, 1);
        chk("R7 R13 temp", temp, exp);
        tick(1);
        chk("R7 valid one cycle", temp_valid, 0);
        ctl_stop();
        chk("R6 idle after read", ctl_ena, 0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        // R1 reset state
        chk("R1 ena", ctl_ena, 0);
        chk("R1 err", err, 0);
        chk("R1 valid", temp_valid, 0);
        chk("R1 temp", temp, 0);
        rst_n = 1'b1;
        tick(2);

        // R11 reread before configuration
        pulse_reread();
        tick(4);
        chk("R11 reread ignored", ctl_ena, 0);

        // R9 stale ack error at start is ignored
        ctl_ack_err = 1'b1;
        pulse_start();
        chk("R2 ena", ctl_ena, 1);
        tick(4);
        chk("R9 ena kept", ctl_ena, 1);
        chk("R9 no err", err, 0);
        ctl_ack_err = 1'b0;

        // R8 real ack error aborts
        ctl_busy = 1'b1; tick(2);
        ctl_ack_err = 1'b1; tick(1);
        chk("R8 err set", err, 1);
        chk("R8 ena dropped", ctl_ena, 0);
        ctl_ack_err = 1'b0; ctl_busy = 1'b0;
        tick(4);
        chk("R8 err sticky", err, 1);
        pulse_reread();
        tick(2);
        chk("R11 reread after error ignored", ctl_ena, 0);

        // Full sequence
        pulse_start();
        chk("R8 err cleared by start", err, 0);
        chk("R2 ena", ctl_ena, 1);
        chk("R2 addr", ctl_addr, 7'b1001000);
        chk("R2 rnw", ctl_rnw, 0);
        chk("R2 pointer cfg", ctl_wr_data, 8'h01);
        ctl_byte(8'h00);
        chk("R3 cfg value", ctl_wr_data, 8'h60);
        chk("R3 ena kept", ctl_ena, 1);
        pulse_start();
        pulse_reread();
        chk("R12 data unchanged", ctl_wr_data, 8'h60);
        chk("R12 rnw unchanged", ctl_rnw, 0);
        ctl_byte(8'h00);
        chk("R4 ena dropped", ctl_ena, 0);
        ctl_stop();
        chk("R5 ena", ctl_ena, 1);
        chk("R5 rnw", ctl_rnw, 0);
        chk("R5 pointer temp", ctl_wr_data, 8'h00);
        ctl_byte(8'h00);
        chk("R5 ena dropped", ctl_ena, 0);
        ctl_stop();
        read_txn(VEC[0][27:20], VEC[0][19:12], VEC[0][11:0]);

        // Vector walk through repeated reads
        for (int i = 1; i < NV; i++) begin
            tick(2);
            pulse_reread();
            chk("R10 reread starts read", ctl_ena, 1);
            read_txn(VEC[i][27:20], VEC[i][19:12], VEC[i][11:0]);
        end
        chk("R13 temp held", temp, VEC[NV-1][11:0]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule